// File: doc/BRIEF.md
# Flash Write Pulse Sequencer

This block runs a single timed program pulse on a flash array. A one-cycle start request begins the sequence. The block then raises a watchdog enable, raises the program-setup control, raises the program control, and lowers them again in reverse order. Each step is held for a cycle count taken from configuration inputs.

The width of the program pulse is picked from three configured widths. The choice depends on the attempt number and on a flag that marks an additional-programming pass. Early attempts get the first width, later attempts get the second, and an additional pass always gets the third.

When the watchdog enable has dropped, the block returns a one-cycle done strobe. The surrounding controller must have set its write-enable before it issues the start. Addressing, data transfer and verify reads belong to other blocks.

Top module: `flash_pulse_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `wdt_en_o`, `setup_o`, `prog_o`, `busy_o` and `done_o` are all 0.
- R2: Once started, the outputs follow a fixed order. First comes one cycle with only `wdt_en_o` high. Then `setup_o` rises, then `prog_o` rises. `prog_o` falls before `setup_o` falls, and `setup_o` falls before `wdt_en_o` falls. `prog_o` is never high without `setup_o`, and `setup_o` is never high without `wdt_en_o`.
- R3: Three phases have configured lengths, counted in clock cycles. The phase with setup high and program low before the pulse lasts `cfg_setup_dly_i`. The phase with setup high after the pulse lasts `cfg_hold_dly_i`. The phase with only the watchdog enable high after setup falls lasts `cfg_release_dly_i`. A configured value of 0 acts as 1.
- R4: When `addl_i` is 0 and `attempt_i` (unsigned) is 6 or less, `prog_o` stays high for `cfg_width1_i` cycles, with 0 acting as 1.
- R5: When `addl_i` is 0 and `attempt_i` is 7 or more, `prog_o` stays high for `cfg_width2_i` cycles, with 0 acting as 1.
- R6: When `addl_i` is 1, `prog_o` stays high for `cfg_width3_i` cycles, whatever `attempt_i` holds.
- R7: The block samples every configuration input, `attempt_i` and `addl_i` in the cycle it accepts the start. Changes to them during the sequence have no effect.
- R8: A start that arrives while `busy_o` is high is ignored, and the sequence in progress keeps its timing.
- R9: A start that arrives while `wr_en_i` is 0 is ignored, and `busy_o` stays 0.
- R10: `busy_o` is high from the cycle after the accepted start until the cycle before `done_o`. There is one cycle with all controls low while `busy_o` is still high. `done_o` is then high for exactly one cycle, with `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start request |
| wr_en_i | input | 1 | Write enable already set by the controller |
| attempt_i | input | 10 | Attempt number of this pulse |
| addl_i | input | 1 | Additional-programming pass |
| cfg_setup_dly_i | input | 16 | Setup-to-pulse delay, cycles |
| cfg_width1_i | input | 16 | Pulse width for early attempts |
| cfg_width2_i | input | 16 | Pulse width for late attempts |
| cfg_width3_i | input | 16 | Pulse width for additional passes |
| cfg_hold_dly_i | input | 16 | Pulse-to-setup-release delay |
| cfg_release_dly_i | input | 16 | Setup-release-to-watchdog-off delay |
| wdt_en_o | output | 1 | Watchdog enable |
| setup_o | output | 1 | Program-setup control |
| prog_o | output | 1 | Program control |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The bench targets the attempt boundary between 6 and 7. A comparator that is off by one there gives the wrong pulse width on one of those two attempts.

It runs an additional pass at a high attempt count. A design that lets the attempt number override the flag would apply the second width instead of the third.

Zero delays show whether a phase is collapsed or made to wrap to a very long count.

Configuration changes and repeated starts during a run show whether the design re-samples its settings or restarts the sequence.

Finally, a start with the write enable low shows whether that qualifier is checked at all.

// File: rtl/fps_pkg.sv
package fps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_RELEASE,
        ST_FINISH
    } fps_state_e;
endpackage

// File: rtl/fps_width_sel.sv
module fps_width_sel #(
    parameter int DLY_W    = 16,
    parameter int ATT_W    = 10,
    parameter int W1_LAST  = 6
) (
    input  logic [ATT_W-1:0] attempt_i,
    input  logic             addl_i,
    input  logic [DLY_W-1:0] width1_i,
    input  logic [DLY_W-1:0] width2_i,
    input  logic [DLY_W-1:0] width3_i,
    output logic [DLY_W-1:0] width_o
);
    localparam logic [ATT_W-1:0] LAST_EARLY = ATT_W'(W1_LAST);

    always_comb begin
        if (addl_i) begin
            width_o = width3_i;
        end else if (attempt_i <= LAST_EARLY) begin
            width_o = width1_i;
        end else begin
            width_o = width2_i;
        end
    end
endmodule

// File: rtl/fps_timer.sv
module fps_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [DLY_W-1:0] load_val_i,
    output logic             expire_o
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    logic [DLY_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q > ONE) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire_o = (cnt_q <= ONE);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q <= ONE) |=> (cnt_q == $past(cnt_q))); // R3
endmodule

// File: rtl/flash_pulse_seq.sv
module flash_pulse_seq #(
    parameter int DLY_W   = 16,
    parameter int ATT_W   = 10,
    parameter int W1_LAST = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             wr_en_i,
    input  logic [ATT_W-1:0] attempt_i,
    input  logic             addl_i,
    input  logic [DLY_W-1:0] cfg_setup_dly_i,
    input  logic [DLY_W-1:0] cfg_width1_i,
    input  logic [DLY_W-1:0] cfg_width2_i,
    input  logic [DLY_W-1:0] cfg_width3_i,
    input  logic [DLY_W-1:0] cfg_hold_dly_i,
    input  logic [DLY_W-1:0] cfg_release_dly_i,
    output logic             wdt_en_o,
    output logic             setup_o,
    output logic             prog_o,
    output logic             busy_o,
    output logic             done_o
);
    import fps_pkg::*;

    typedef struct packed {
        fps_state_e       state;
        logic             wdt;
        logic             setup;
        logic             prog;
        logic             done;
        logic [DLY_W-1:0] dly_setup;
        logic [DLY_W-1:0] dly_pulse;
        logic [DLY_W-1:0] dly_hold;
        logic [DLY_W-1:0] dly_rel;
    } fps_regs_t;

    fps_regs_t        r_d, r_q;
    logic [DLY_W-1:0] sel_width;
    logic             tmr_load;
    logic [DLY_W-1:0] tmr_val;
    logic             tmr_expire;

    fps_width_sel #(
        .DLY_W   (DLY_W),
        .ATT_W   (ATT_W),
        .W1_LAST (W1_LAST)
    ) i_width_sel (
        .attempt_i (attempt_i),
        .addl_i    (addl_i),
        .width1_i  (cfg_width1_i),
        .width2_i  (cfg_width2_i),
        .width3_i  (cfg_width3_i),
        .width_o   (sel_width)
    );

    fps_timer #(
        .DLY_W (DLY_W)
    ) i_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expire_o   (tmr_expire)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i && wr_en_i) begin
                    r_d.state     = ST_ARM;
                    r_d.wdt       = 1'b1;
                    r_d.dly_setup = cfg_setup_dly_i;
                    r_d.dly_pulse = sel_width;
                    r_d.dly_hold  = cfg_hold_dly_i;
                    r_d.dly_rel   = cfg_release_dly_i;
                end
            end
            ST_ARM: begin
                r_d.state = ST_SETUP;
                r_d.setup = 1'b1;
                tmr_load  = 1'b1;
                tmr_val   = r_q.dly_setup;
            end
            ST_SETUP: begin
                if (tmr_expire) begin
                    r_d.state = ST_PULSE;
                    r_d.prog  = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = r_q.dly_pulse;
                end
            end
            ST_PULSE: begin
                if (tmr_expire) begin
                    r_d.state = ST_HOLD;
                    r_d.prog  = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = r_q.dly_hold;
                end
            end
            ST_HOLD: begin
                if (tmr_expire) begin
                    r_d.state = ST_RELEASE;
                    r_d.setup = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = r_q.dly_rel;
                end
            end
            ST_RELEASE: begin
                if (tmr_expire) begin
                    r_d.state = ST_FINISH;
                    r_d.wdt   = 1'b0;
                end
            end
            ST_FINISH: begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
            end
            default: begin
                r_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wdt_en_o = r_q.wdt;
    assign setup_o  = r_q.setup;
    assign prog_o   = r_q.prog;
    assign done_o   = r_q.done;
    assign busy_o   = (r_q.state != ST_IDLE);

    AST_PROG_UNDER_SETUP: assert property (@(posedge clk) disable iff (rst)
        prog_o |-> (setup_o && wdt_en_o)); // R2
    AST_SETUP_UNDER_WDT: assert property (@(posedge clk) disable iff (rst)
        setup_o |-> wdt_en_o); // R2
    AST_PROG_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_o) |-> $past(setup_o)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!wdt_en_o && !setup_o && !prog_o)); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R10
    AST_DONE_AFTER_WDT_LOW: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(!wdt_en_o) && !busy_o)); // R10
    AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i && wr_en_i)); // R9
endmodule

// File: tb/test_flash_pulse_seq.sv
module test_flash_pulse_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic        wr_en_i;
    logic [9:0]  attempt_i;
    logic        addl_i;
    logic [15:0] cfg_setup_dly_i, cfg_width1_i, cfg_width2_i, cfg_width3_i;
    logic [15:0] cfg_hold_dly_i, cfg_release_dly_i;
    logic        wdt_en_o, setup_o, prog_o, busy_o, done_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    flash_pulse_seq i_flash_pulse_seq (
        .clk (clk), .rst (rst), .start_i (start_i), .wr_en_i (wr_en_i),
        .attempt_i (attempt_i), .addl_i (addl_i),
        .cfg_setup_dly_i (cfg_setup_dly_i), .cfg_width1_i (cfg_width1_i),
        .cfg_width2_i (cfg_width2_i), .cfg_width3_i (cfg_width3_i),
        .cfg_hold_dly_i (cfg_hold_dly_i), .cfg_release_dly_i (cfg_release_dly_i),
        .wdt_en_o (wdt_en_o), .setup_o (setup_o), .prog_o (prog_o),
        .busy_o (busy_o), .done_o (done_o)
    );

    function automatic int at_least1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int pick_width(input int att, input bit addl,
                                      input int w1, input int w2, input int w3);
        if (addl) return at_least1(w3);
        if (att <= 6) return at_least1(w1);
        return at_least1(w2);
    endfunction

    // bits: {wdt, setup, prog, busy, done}; k = cycles after the accepting edge
    function automatic logic [4:0] exp_at(input int k, input int a, input int w,
                                          input int h, input int r);
        int b;
        if (k == 1) return 5'b10010;
        b = 1;
        if (k <= b + a) return 5'b11010;
        b += a;
        if (k <= b + w) return 5'b11110;
        b += w;
        if (k <= b + h) return 5'b11010;
        b += h;
        if (k <= b + r) return 5'b10010;
        b += r;
        if (k == b + 1) return 5'b00010;
        if (k == b + 2) return 5'b00001;
        return 5'b00000;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic run_one(input int y, input int w1, input int w2, input int w3,
                           input int hd, input int rl, input int att, input bit addl,
                           input bit poke, input string wreq);
        int a, w, h, r, total, prog_cnt, bad_k;
        logic [4:0] got, expv, bad_got, bad_exp;
        a = at_least1(y); w = pick_width(att, addl, w1, w2, w3);
        h = at_least1(hd); r = at_least1(rl);
        total = 1 + a + w + h + r + 3;
        prog_cnt = 0; bad_k = 0; bad_got = '0; bad_exp = '0;
        @(negedge clk);
        start_i = 1'b1; wr_en_i = 1'b1;
        attempt_i = 10'(att); addl_i = addl;
        cfg_setup_dly_i = 16'(y); cfg_width1_i = 16'(w1); cfg_width2_i = 16'(w2);
        cfg_width3_i = 16'(w3); cfg_hold_dly_i = 16'(hd); cfg_release_dly_i = 16'(rl);
        for (int k = 1; k <= total; k++) begin
            @(negedge clk);
            if (k == 1) begin
                // R7: scramble every sampled input after acceptance
                start_i = 1'b0;
                attempt_i = ~attempt_i; addl_i = ~addl_i;
                cfg_setup_dly_i = 16'd40; cfg_width1_i = 16'd41; cfg_width2_i = 16'd42;
                cfg_width3_i = 16'd43; cfg_hold_dly_i = 16'd44; cfg_release_dly_i = 16'd45;
            end
            got  = {wdt_en_o, setup_o, prog_o, busy_o, done_o};
            expv = exp_at(k, a, w, h, r);
            if (prog_o) prog_cnt++;
            if (got !== expv && bad_k == 0) begin
                bad_k = k; bad_got = got; bad_exp = expv;
            end
            // R8: repeated starts while busy
            start_i = (poke && k >= 2 && k <= total - 3) ? ($urandom_range(0, 1) == 1) : 1'b0;
        end
        start_i = 1'b0;
        check(bad_k == 0, poke ? "R8 sequence under busy starts" : "R2 R3 R7 R10 sequence",
              int'(bad_got), int'(bad_exp));
        check(prog_cnt == w, wreq, prog_cnt, w);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; start_i = 1'b0; wr_en_i = 1'b0; attempt_i = '0; addl_i = 1'b0;
        cfg_setup_dly_i = '0; cfg_width1_i = '0; cfg_width2_i = '0; cfg_width3_i = '0;
        cfg_hold_dly_i = '0; cfg_release_dly_i = '0;
        repeat (3) @(negedge clk);
        check({wdt_en_o, setup_o, prog_o, busy_o, done_o} == 5'b0, "R1 reset outputs",
              int'({wdt_en_o, setup_o, prog_o, busy_o, done_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        check({wdt_en_o, setup_o, prog_o, busy_o, done_o} == 5'b0, "R1 after reset",
              int'({wdt_en_o, setup_o, prog_o, busy_o, done_o}), 0);

        // R9: start without write enable
        start_i = 1'b1; wr_en_i = 1'b0; cfg_setup_dly_i = 16'd3;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) begin
            check(!busy_o && !wdt_en_o, "R9 start ignored without write enable",
                  int'({busy_o, wdt_en_o}), 0);
            @(negedge clk);
        end

        run_one(3, 5, 9, 2, 4, 2, 6, 1'b0, 1'b0, "R4 width at attempt 6");
        run_one(3, 5, 9, 2, 4, 2, 7, 1'b0, 1'b0, "R5 width at attempt 7");
        run_one(2, 5, 9, 3, 1, 1, 1000, 1'b1, 1'b0, "R6 additional width at attempt 1000");
        run_one(2, 4, 6, 8, 2, 2, 0, 1'b0, 1'b0, "R4 width at attempt 0");
        run_one(0, 0, 0, 0, 0, 0, 3, 1'b0, 1'b0, "R3 R4 zero delays act as one");
        run_one(0, 7, 0, 0, 0, 0, 9, 1'b0, 1'b0, "R5 zero width2 acts as one");
        run_one(2, 6, 3, 5, 3, 2, 2, 1'b0, 1'b1, "R8 width unchanged by busy start");

        for (int i = 0; i < 30; i++) begin
            int att;
            bit ad;
            att = $urandom_range(0, 1023);
            ad  = ($urandom_range(0, 3) == 0);
            run_one($urandom_range(0, 12), $urandom_range(0, 15), $urandom_range(0, 15),
                    $urandom_range(0, 15), $urandom_range(0, 12), $urandom_range(0, 12),
                    att, ad, ($urandom_range(0, 2) == 0),
                    ad ? "R6 random width" : (att <= 6 ? "R4 random width" : "R5 random width"));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule